// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses the two ALU operands for the instruction currently in the execute stage of a five-stage in-order pipeline. The values read from the register file during decode may be stale when one of the two instructions ahead of it has not yet written its result back. The block compares the execute-stage source register numbers with the destinations of the instructions in the memory and write-back stages. It then steers either the register-file value, the memory-stage ALU result or the write-back value onto each operand.

The logic is purely combinational. It reports a 2-bit select code per operand. Code 00 takes the register-file value, 10 takes the memory-stage result and 01 takes the write-back value; code 11 is never produced, and the internal multiplexer treats it like 00. When both later stages hold a writer of the same source register, the newer memory-stage result wins. A producer whose destination is register zero, or that does not write a register at all, is never bypassed. Instructions that complete write-back in the same cycle as a decode-stage read are covered by a write-through register file, so no third bypass path exists.

Top module: `opfwd_unit`

## Requirements
- R1: When the memory-stage write flag is 1, its destination is non-zero and equals an operand's source register, that operand's select is 10 and the operand equals the memory-stage result.
- R2: When R1 does not apply to an operand, but the write-back-stage write flag is 1 and its destination is non-zero and equals the source, the select is 01 and the operand equals the write-back value.
- R3: When both the memory stage and the write-back stage qualify for the same source, the memory-stage result is chosen (select 10).
- R4: A producer whose destination is register 0 never causes bypassing, even when the source is also register 0.
- R5: A destination match from a producer whose write flag is 0 never causes bypassing.
- R6: When no producer qualifies, the select is 00 and the operand equals the register-file value; the select code 11 never appears.
- R7: Over back-to-back dependent instruction streams, including three successive writes to one register, each operand equals the architectural value of its source register produced by the most recent earlier writer.
- R8: Outputs follow the inputs within the same cycle; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| rf_val_a | input | 32 | Register-file value read for the first source |
| rf_val_b | input | 32 | Register-file value read for the second source |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_value | input | 32 | Value being written back |
| sel_a | output | 2 | Select code for the first operand |
| sel_b | output | 2 | Select code for the second operand |
| opnd_a | output | 32 | First ALU operand |
| opnd_b | output | 32 | Second ALU operand |

## Verification
The bench builds the block with its default parameters: 5-bit register numbers, 32-bit data and register zero treated as hardwired. The bench confines random register numbers to 0..3. Matches against both stages, simultaneous matches, and writes to register zero therefore occur often within a few hundred instructions. Directed sequences at the start place three successive writers of one register back to back, a write to register zero and a non-writing producer with a matching destination.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WBACK   = 2'b01,
        SEL_MEMSTG  = 2'b10,
        SEL_SPARE   = 2'b11
    } fwd_sel_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/opfwd_hit.sv
module opfwd_hit #(
    parameter int unsigned AW         = 5,
    parameter bit          ZERO_FIXED = 1'b1
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wr,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic same;
    assign same = (dst == src);

    generate
        if (ZERO_FIXED) begin : g_zero_guard
            assign hit = wr && same && (dst != ZERO_REG);
        end else begin : g_no_guard
            assign hit = wr && same;
        end
    endgenerate
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = SEL_MEMSTG;
            2'b01:        sel = SEL_WBACK;
            default:      sel = SEL_REGFILE;
        endcase
    end
endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  fwd_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (sel)
            SEL_MEMSTG: y = mem_val;
            SEL_WBACK:  y = wb_val;
            SEL_SPARE:  y = rf_val;
            default:    y = rf_val;
        endcase
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int unsigned AW         = 5,
    parameter int unsigned DW         = 32,
    parameter bit          ZERO_FIXED = 1'b1
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    input  logic [DW-1:0] rf_val_a,
    input  logic [DW-1:0] rf_val_b,
    input  logic [DW-1:0] mem_result,
    input  logic [DW-1:0] wb_value,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    logic [AW-1:0] src_v [NUM_OPERANDS];
    logic [DW-1:0] rf_v  [NUM_OPERANDS];
    logic [DW-1:0] out_v [NUM_OPERANDS];
    fwd_sel_e      sel_v [NUM_OPERANDS];

    assign src_v[0] = ex_src_a;
    assign src_v[1] = ex_src_b;
    assign rf_v[0]  = rf_val_a;
    assign rf_v[1]  = rf_val_b;

    generate
        for (genvar k = 0; k < NUM_OPERANDS; k++) begin : g_opnd
            logic mem_hit;
            logic wb_hit;

            opfwd_hit #(.AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_mem_hit (
                .src(src_v[k]), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit)
            );
            opfwd_hit #(.AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_wb_hit (
                .src(src_v[k]), .dst(wb_dst), .wr(wb_wr), .hit(wb_hit)
            );
            opfwd_pick u_pick (
                .mem_hit(mem_hit), .wb_hit(wb_hit), .sel(sel_v[k])
            );
            opfwd_mux #(.DW(DW)) u_mux (
                .sel(sel_v[k]), .rf_val(rf_v[k]), .mem_val(mem_result),
                .wb_val(wb_value), .y(out_v[k])
            );
        end
    endgenerate

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = out_v[0];
    assign opnd_b = out_v[1];
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic [AW-1:0] mem_dst,
    input logic          mem_wr,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wr,
    input logic [DW-1:0] rf_val_a,
    input logic [DW-1:0] rf_val_b,
    input logic [DW-1:0] mem_result,
    input logic [DW-1:0] wb_value,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b
);
    logic known;
    assign known = !$isunknown({ex_src_a, ex_src_b, mem_dst, mem_wr, wb_dst, wb_wr,
                                rf_val_a, rf_val_b, mem_result, wb_value});

    always_comb begin
        if (known) begin
            if (mem_wr && mem_dst != '0 && mem_dst == ex_src_a)
                assert_mem_first_a_R1: assert (sel_a == 2'b10 && opnd_a == mem_result)
                    else $error("bypass A missed memory stage");
            if (mem_wr && mem_dst != '0 && mem_dst == ex_src_b)
                assert_mem_first_b_R3: assert (sel_b == 2'b10 && opnd_b == mem_result)
                    else $error("bypass B missed memory stage");
            if (!(mem_wr && mem_dst == ex_src_a) && wb_wr && wb_dst != '0 && wb_dst == ex_src_a)
                assert_wb_path_a_R2: assert (sel_a == 2'b01 && opnd_a == wb_value)
                    else $error("bypass A missed write-back stage");
            if (!(mem_wr && mem_dst == ex_src_b) && wb_wr && wb_dst != '0 && wb_dst == ex_src_b)
                assert_wb_path_b_R2: assert (sel_b == 2'b01 && opnd_b == wb_value)
                    else $error("bypass B missed write-back stage");
            if (ex_src_a == '0)
                assert_zero_src_a_R4: assert (sel_a == 2'b00)
                    else $error("register zero bypassed on A");
            if (!mem_wr && !wb_wr)
                assert_idle_b_R5: assert (sel_b == 2'b00 && opnd_b == rf_val_b)
                    else $error("non-writing producer bypassed on B");
            assert_no_spare_R6: assert (sel_a != 2'b11 && sel_b != 2'b11)
                else $error("spare select code produced");
        end
    end
endmodule

bind opfwd_unit opfwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .mem_result(mem_result), .wb_value(wb_value), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/opfwd_unit_test.sv
module opfwd_unit_test;
    localparam int N = 320;
    localparam int ND = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [4:0]  ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic        mem_wr, wb_wr;
    logic [31:0] rf_val_a, rf_val_b, mem_result, wb_value;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    opfwd_unit uut (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .mem_result(mem_result), .wb_value(wb_value), .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    int checks = 0;
    int fails  = 0;

    int          i_dst [N];
    bit          i_wr  [N];
    int          i_sa  [N];
    int          i_sb  [N];
    logic [31:0] i_res [N];

    function automatic logic [31:0] init_val(int r);
        return (r == 0) ? 32'h0 : 32'h1000_0000 + 32'(r) * 32'h0101;
    endfunction

    // value of register r after instructions 0..upto have retired
    function automatic logic [31:0] arch_val(int r, int upto);
        if (r == 0) return 32'h0;
        for (int j = upto; j >= 0; j--)
            if (i_wr[j] && i_dst[j] == r) return i_res[j];
        return init_val(r);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string classify(int src, int i);
        bit mh, wh;
        mh = (i >= 1) && i_wr[i-1] && i_dst[i-1] == src && src != 0;
        wh = (i >= 2) && i_wr[i-2] && i_dst[i-2] == src && src != 0;
        if (mh && wh) return "R3";
        if (mh) return "R1";
        if (wh) return "R2";
        if (src == 0 && ((i >= 1 && i_dst[i-1] == 0 && i_wr[i-1]) ||
                         (i >= 2 && i_dst[i-2] == 0 && i_wr[i-2]))) return "R4";
        if ((i >= 1 && !i_wr[i-1] && i_dst[i-1] == src) ||
            (i >= 2 && !i_wr[i-2] && i_dst[i-2] == src)) return "R5";
        return "R6";
    endfunction

    function automatic logic [1:0] exp_sel(int src, int i);
        if (src != 0 && i >= 1 && i_wr[i-1] && i_dst[i-1] == src) return 2'b10;
        if (src != 0 && i >= 2 && i_wr[i-2] && i_dst[i-2] == src) return 2'b01;
        return 2'b00;
    endfunction

    initial begin
        int dd [ND] = '{1, 1, 1, 4, 0, 2, 5};
        bit dw [ND] = '{1, 1, 1, 1, 1, 0, 1};
        int da [ND] = '{0, 1, 1, 1, 0, 0, 2};
        int db [ND] = '{0, 2, 3, 1, 0, 2, 0};
        for (int j = 0; j < N; j++) begin
            if (j < ND) begin
                i_dst[j] = dd[j]; i_wr[j] = dw[j]; i_sa[j] = da[j]; i_sb[j] = db[j];
            end else begin
                i_dst[j] = int'($urandom_range(0, 3));
                i_wr[j]  = ($urandom_range(0, 3) != 0);
                i_sa[j]  = int'($urandom_range(0, 3));
                i_sb[j]  = int'($urandom_range(0, 3));
            end
            i_res[j] = $urandom;
        end

        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_wr = 1'b0; wb_wr = 1'b0;
        rf_val_a = 32'h1111_2222; rf_val_b = 32'h3333_4444;
        mem_result = 32'hAAAA_0000; wb_value = 32'hBBBB_0000;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sel_a == 2'b00 && sel_b == 2'b00, "R6 idle select", {30'd0, sel_a}, 32'd0);
        check(opnd_a == 32'h1111_2222 && opnd_b == 32'h3333_4444, "R6 idle operand",
              opnd_a, 32'h1111_2222);

        for (int i = 0; i < N; i++) begin
            @(posedge clk);
            #1;
            ex_src_a = 5'(i_sa[i]);
            ex_src_b = 5'(i_sb[i]);
            mem_dst  = (i >= 1) ? 5'(i_dst[i-1]) : 5'd0;
            mem_wr   = (i >= 1) ? i_wr[i-1] : 1'b0;
            wb_dst   = (i >= 2) ? 5'(i_dst[i-2]) : 5'd0;
            wb_wr    = (i >= 2) ? i_wr[i-2] : 1'b0;
            mem_result = (i >= 1) ? i_res[i-1] : 32'hDEAD_0001;
            wb_value   = (i >= 2) ? i_res[i-2] : 32'hDEAD_0002;
            rf_val_a = arch_val(i_sa[i], i - 3);
            rf_val_b = arch_val(i_sb[i], i - 3);
            @(negedge clk);
            check(sel_a == exp_sel(i_sa[i], i), classify(i_sa[i], i),
                  {30'd0, sel_a}, {30'd0, exp_sel(i_sa[i], i)});
            check(sel_b == exp_sel(i_sb[i], i), classify(i_sb[i], i),
                  {30'd0, sel_b}, {30'd0, exp_sel(i_sb[i], i)});
            check(opnd_a == arch_val(i_sa[i], i - 1), "R7 operand A", opnd_a,
                  arch_val(i_sa[i], i - 1));
            check(opnd_b == arch_val(i_sb[i], i - 1), "R7 operand B", opnd_b,
                  arch_val(i_sb[i], i - 1));
        end

        // R8: a mid-cycle change of the bypassed value appears at once
        @(posedge clk);
        #1;
        ex_src_a = 5'd6; mem_dst = 5'd6; mem_wr = 1'b1; wb_wr = 1'b0;
        mem_result = 32'h0000_5555;
        #1;
        check(opnd_a == 32'h0000_5555, "R8 first value", opnd_a, 32'h0000_5555);
        mem_result = 32'h0000_7777;
        #1;
        check(opnd_a == 32'h0000_7777, "R8 follows input", opnd_a, 32'h0000_7777);
        mem_wr = 1'b0;
        rf_val_a = 32'h0000_9999;
        #1;
        check(sel_a == 2'b00 && opnd_a == 32'h0000_9999, "R8 drop to register file",
              opnd_a, 32'h0000_9999);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule